// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block keeps the alarm settings of a real-time clock and checks them against the clock's packed-BCD time and date counters. It has six alarm fields: seconds, minutes, hours, day of week, day of month and month. Each field is an 8-bit register on a small synchronous register bus. Bit 7 of each register switches comparison on for that field. The remaining bits hold the BCD alarm value, masked to the width the field needs.

The counters arrive from outside together with a one-cycle strobe that marks the cycle on which they advance. The comparison happens only on that strobe. If at least one field is enabled and every enabled field equals its counter, the block sets a sticky alarm flag. Software reads this flag and clears it by writing 0 to the flag register. Reset clears the enable bits and the flag. The stored alarm values are not touched by reset, so a preset alarm value survives a reset with its comparison switched off.

Top module: `rtc_alarm_match`

## Requirements
- R1: Addresses 0 to 5 select the seconds, minutes, hours, day-of-week, day-of-month and month alarm registers, in that order. A write (`reg_we` high) takes effect at the clock edge. `reg_rdata` is registered: it shows the register selected by `reg_addr` one clock after the address is presented.
- R2: Bit 7 of each alarm register is its compare enable. Reset clears every enable bit to 0 and leaves the value bits as they were. Value bits start at all zero.
- R3: The value bits are 6:0 for seconds and minutes, 5:0 for hours and day of month, 2:0 for day of week and 4:0 for month. Any other bit below bit 7 reads as 0 and ignores writes. This includes bit 6 of the day-of-month register.
- R4: On a clock edge where `cnt_tick` is 1, the alarm flag becomes 1 if every enabled field's value equals the same bits of its counter. Fields whose enable is 0 do not take part, and counter bits outside a field's value bits are ignored.
- R5: When no field has its enable bit set, the alarm flag is never set.
- R6: On an edge where `cnt_tick` is 0, the alarm flag is not set, even when all enabled fields match.
- R7: The alarm flag stays 1 until a write to address 6 with data bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged. If a clear and a match happen on the same edge, the flag is 1.
- R8: Address 6 reads the alarm flag in bit 0 with zeros above it. Address 7 reads as 0. Reset clears the flag and `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_tick | input | 1 | One-cycle strobe when the counters advance |
| cnt_sec | input | 7 | BCD seconds counter |
| cnt_min | input | 7 | BCD minutes counter |
| cnt_hour | input | 7 | BCD hours counter |
| cnt_wday | input | 7 | Day-of-week counter |
| cnt_mday | input | 7 | BCD day-of-month counter |
| cnt_mon | input | 7 | BCD month counter |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The assertions check on every cycle that the flag is sticky unless a clear write arrives, and that it never rises without a tick or with every enable off. They also check that a full match on a tick always sets the flag, that reset leaves all enables at zero, and that bit 6 of the day-of-month read is always zero. Other behaviour needs the bench's scenarios. These include a stored value surviving a reset while its enable clears, and the masking of each field's unused bits on readback. They also include correct matching over many random mixes of enables and counters, and a clear and a match landing on the same edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NFIELD    = 6;
  localparam int DATA_W    = 8;
  localparam int VAL_W     = DATA_W - 1;
  localparam int ADDR_W    = 3;
  localparam int FLAG_ADDR = NFIELD;

  // Value bits each field keeps (BCD width of the field)
  function automatic logic [VAL_W-1:0] field_mask(input int idx);
    case (idx)
      0, 1:    return 7'h7F;  // seconds, minutes
      2, 4:    return 7'h3F;  // hours, day of month
      3:       return 7'h07;  // day of week
      default: return 7'h1F;  // month
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field
  import rtc_alarm_pkg::*;
#(
  parameter logic [VAL_W-1:0] VAL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [VAL_W-1:0]  cnt,
  output logic [DATA_W-1:0] rd_val,
  output logic              en,
  output logic              eq
);
  logic [VAL_W-1:0] val = '0;

  // Enable bit: cleared by reset
  always_ff @(posedge clk) begin
    if (rst)     en <= 1'b0;
    else if (wr) en <= wdata[DATA_W-1];
  end

  // Value bits: not reset, only masked bits are stored
  always_ff @(posedge clk) begin
    if (wr && !rst) val <= wdata[VAL_W-1:0] & VAL_MASK;
  end

  assign rd_val = {en, val};
  assign eq     = ((cnt & VAL_MASK) == val);
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | hit;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cnt_tick,
  input  logic [VAL_W-1:0]  cnt_sec,
  input  logic [VAL_W-1:0]  cnt_min,
  input  logic [VAL_W-1:0]  cnt_hour,
  input  logic [VAL_W-1:0]  cnt_wday,
  input  logic [VAL_W-1:0]  cnt_mday,
  input  logic [VAL_W-1:0]  cnt_mon,
  output logic              alarm_flag
);
  logic [VAL_W-1:0]  cnt_vec [NFIELD];
  logic [DATA_W-1:0] rd_vec  [NFIELD];
  logic [NFIELD-1:0] en_vec;
  logic [NFIELD-1:0] eq_vec;
  logic              hit;
  logic              clr;
  logic [DATA_W-1:0] rd_mux;

  assign cnt_vec[0] = cnt_sec;
  assign cnt_vec[1] = cnt_min;
  assign cnt_vec[2] = cnt_hour;
  assign cnt_vec[3] = cnt_wday;
  assign cnt_vec[4] = cnt_mday;
  assign cnt_vec[5] = cnt_mon;

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    rtc_alarm_field #(.VAL_MASK(field_mask(g))) u_field (
      .clk    (clk),
      .rst    (rst),
      .wr     (reg_we && (reg_addr == ADDR_W'(g))),
      .wdata  (reg_wdata),
      .cnt    (cnt_vec[g]),
      .rd_val (rd_vec[g]),
      .en     (en_vec[g]),
      .eq     (eq_vec[g])
    );
  end

  assign hit = cnt_tick && (|en_vec) && (&(eq_vec | ~en_vec));
  assign clr = reg_we && (reg_addr == ADDR_W'(FLAG_ADDR)) && !reg_wdata[0];

  rtc_alarm_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .hit  (hit),
    .flag (alarm_flag)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NFIELD; i++)
      if (reg_addr == ADDR_W'(i)) rd_mux = rd_vec[i];
    if (reg_addr == ADDR_W'(FLAG_ADDR)) rd_mux = {{(DATA_W-1){1'b0}}, alarm_flag};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              cnt_tick,
  input logic              alarm_flag,
  input logic [NFIELD-1:0] en_vec,
  input logic [NFIELD-1:0] eq_vec
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == ADDR_W'(FLAG_ADDR)) && !reg_wdata[0];

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !clr_wr) |=> alarm_flag);

  a_r5_no_enable_no_set: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && en_vec == '0) |=> !alarm_flag);

  a_r6_no_tick_no_set: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && !cnt_tick) |=> !alarm_flag);

  a_r4_match_sets: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && en_vec != '0 && ((eq_vec | ~en_vec) == '1)) |=> alarm_flag);

  a_r2_enable_reset: assert property (@(posedge clk)
    $past(rst) |-> (en_vec == '0));

  a_r3_mday_bit6: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == ADDR_W'(4)) |-> !reg_rdata[6]);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .cnt_tick   (cnt_tick),
  .alarm_flag (alarm_flag),
  .en_vec     (en_vec),
  .eq_vec     (eq_vec)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic [6:0] cnt [6];
  logic       flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0] mval [6];
  logic       men  [6];
  logic       mflag = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .cnt_tick(tick),
    .cnt_sec(cnt[0]), .cnt_min(cnt[1]), .cnt_hour(cnt[2]),
    .cnt_wday(cnt[3]), .cnt_mday(cnt[4]), .cnt_mon(cnt[5]),
    .alarm_flag(flag)
  );

  function automatic logic [6:0] fmask(input int i);
    logic [6:0] m [6] = '{7'h7F, 7'h7F, 7'h3F, 7'h07, 7'h3F, 7'h1F};
    return m[i];
  endfunction

  function automatic logic [7:0] mread(input logic [2:0] a);
    if (a < 3'd6) return {men[a], mval[a]};
    if (a == 3'd6) return {7'b0, mflag};
    return 8'h00;
  endfunction

  function automatic bit mhit(input bit t);
    bit any = 0;
    bit ok = 1;
    for (int i = 0; i < 6; i++)
      if (men[i]) begin
        any = 1;
        if ((cnt[i] & fmask(i)) != mval[i]) ok = 0;
      end
    return t && any && ok;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the model, check outputs after the edge
  task automatic step(input string tag, input bit r, input bit w,
                      input logic [2:0] a, input logic [7:0] d, input bit t);
    logic [7:0] erd;
    bit h;
    rst = r; we = w; addr = a; wdata = d; tick = t;
    erd = mread(a);
    h = mhit(t);
    if (r) begin
      for (int i = 0; i < 6; i++) men[i] = 1'b0;
      mflag = 1'b0;
      erd = 8'h00;
    end else begin
      if (w && a < 3'd6) begin
        men[a] = d[7];
        mval[a] = d[6:0] & fmask(a);
      end
      if (w && a == 3'd6 && !d[0]) mflag = 1'b0;
      if (h) mflag = 1'b1;
    end
    @(posedge clk);
    #1;
    chk({tag, " rdata"}, rdata, erd);
    chk({tag, " flag"}, {7'b0, flag}, {7'b0, mflag});
  endtask

  task automatic set_cnt_to_alarm();
    for (int i = 0; i < 6; i++) cnt[i] = mval[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin cnt[i] = '0; mval[i] = '0; men[i] = 1'b0; end
    #1;
    step("R8 reset", 1, 0, 3'd0, 8'h00, 0);
    step("R8 reset", 1, 0, 3'd0, 8'h00, 0);
    // R2 reset state: all registers read zero
    for (int a = 0; a < 8; a++) step("R2 reset read", 0, 0, 3'(a), 8'h00, 0);
    // R3 masking of unused bits
    step("R3 write mday", 0, 1, 3'd4, 8'hFF, 0);
    step("R3 read mday bit6", 0, 0, 3'd4, 8'h00, 0);
    chk("R3 mday readback", rdata, 8'hBF);
    step("R3 write wday", 0, 1, 3'd3, 8'hFF, 0);
    step("R3 read wday", 0, 0, 3'd3, 8'h00, 0);
    chk("R3 wday readback", rdata, 8'h87);
    step("R1 write mon", 0, 1, 3'd5, 8'h92, 0);
    step("R1 read mon", 0, 0, 3'd5, 8'h00, 0);
    // R2 reset keeps value, clears enable
    step("R2 reset", 1, 0, 3'd4, 8'h00, 0);
    step("R2 read mday after reset", 0, 0, 3'd4, 8'h00, 0);
    chk("R2 mday value kept", rdata, 8'h3F);
    // R5 no enables: matching counters on tick never set
    set_cnt_to_alarm();
    step("R5 no enable tick", 0, 0, 3'd6, 8'h00, 1);
    step("R5 no enable tick", 0, 0, 3'd6, 8'h00, 1);
    chk("R5 flag clear", {7'b0, flag}, 8'h00);
    // R6 enabled match without tick
    step("R6 enable sec", 0, 1, 3'd0, 8'hC5, 0);
    set_cnt_to_alarm();
    cnt[1] = 7'h11;
    step("R6 no tick", 0, 0, 3'd6, 8'h00, 0);
    chk("R6 flag clear", {7'b0, flag}, 8'h00);
    // R4 tick with match; disabled fields differ
    step("R4 tick match", 0, 0, 3'd6, 8'h00, 1);
    chk("R4 flag set", {7'b0, flag}, 8'h01);
    // R7 sticky and clear behaviour
    step("R7 write one", 0, 1, 3'd6, 8'h01, 0);
    chk("R7 flag kept", {7'b0, flag}, 8'h01);
    step("R7 clear with hit", 0, 1, 3'd6, 8'h00, 1);
    chk("R7 clear+hit", {7'b0, flag}, 8'h01);
    step("R7 clear", 0, 1, 3'd6, 8'hFE, 0);
    chk("R7 cleared", {7'b0, flag}, 8'h00);
    // R4 mismatch in an enabled field
    cnt[0] = 7'h46;
    step("R4 mismatch", 0, 0, 3'd7, 8'h00, 1);
    chk("R4 no set on mismatch", {7'b0, flag}, 8'h00);
    chk("R8 addr7 reads zero", rdata, 8'h00);
    // R1/R4 random mix
    for (int k = 0; k < 3000; k++) begin
      bit w = ($urandom % 4) == 0;
      logic [2:0] a = 3'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      if (a == 3'd6 && w) d[0] = ($urandom % 2);
      for (int i = 0; i < 6; i++)
        cnt[i] = (($urandom % 4) != 0) ? (mval[i] | (7'($urandom) & ~fmask(i)))
                                       : 7'($urandom);
      step("R1/R4 random", 0, w, a, d, ($urandom % 2) == 1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule